// File: doc/BRIEF.md
# Configuration Authentication Outcome Controller

This block sequences what happens to an incoming configuration image once its authentication verdicts are in. Two abstract engines sit beside it: an asymmetric-signature checker, which reports when the image has been buffered and when the expected digest has been derived, and an authenticated-decryption engine, which reports a pass/fail tag verdict. The controller compares the actual digest against the expected digest with a full-width equality check. It then commands startup, decryption, a clear of configuration state, a fallback load, or a lock of the configuration interface.

A signature mismatch and a decryption tag failure feed one shared error path. With the fallback strap set, an error first clears all state and then loads the fallback image. Without the strap, or when the fallback image also fails, the interface is locked. Only a power-on reset or a validated program request can leave the lock. The program request is asynchronous. It is synchronised through two flops and must be seen high on two successive synchronised samples before it is acted on.

Top module: `cfg_auth_ctrl`

## Requirements
- R1: While `por_n` is low, `state_oh` is 8'b0000_0001 (idle), every command output is low and `auth_error` is low. The one-hot state bits are: bit0 idle, bit1 buffering, bit2 signature compare, bit3 decrypting, bit4 clearing, bit5 fallback load, bit6 startup, bit7 locked. Exactly one bit is ever set.
- R2: A `start` with `sig_en` high enters buffering (`buffer_cmd` high). The controller stays there until both `buf_done` and `hash_done` have been seen, in either order or together. It then spends one cycle in signature compare.
- R3: On a digest match with the image marked unencrypted (the `encrypted` value sampled at `start`), the cycle after compare enters startup (`startup_cmd` high). Startup holds until reset.
- R4: On a digest match with an encrypted image, the controller enters decrypting (`decrypt_cmd` high). `decrypt_cmd` is never high while the signature path is buffering or comparing.
- R5: A digest differing in any single bit of the 256 is an authentication error. It takes the same error path as a `dec_done` with `dec_pass` low, and it never reaches startup.
- R6: On an error with `fallback_en` high, `clear_cmd` is held until `clr_done`. The next cycle enters fallback load (`fallback_cmd` high). `auth_error` goes high on the error and stays high until reset or a valid program request.
- R7: On an error with `fallback_en` low, the state becomes locked (`if_locked` high). All `start`, done and pass inputs are then ignored.
- R8: `prog_req` held high for at least 4 clocks returns the controller to idle and clears `auth_error`. A `prog_req` high for a single clock has no effect.
- R9: An error while processing the fallback image leads to locked, even with `fallback_en` high.
- R10: A `start` with `sig_en` low goes directly to decrypting if `encrypted` is high, else directly to startup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| prog_req | input | 1 | Asynchronous program request |
| start | input | 1 | An image begins arriving (idle or fallback load) |
| encrypted | input | 1 | Image is encrypted, sampled with start |
| sig_en | input | 1 | Signature checking enabled for this image |
| fallback_en | input | 1 | Fallback strap |
| buf_done | input | 1 | Whole image buffered |
| hash_done | input | 1 | Expected digest computed |
| exp_digest | input | 256 | Expected digest |
| act_digest | input | 256 | Actual digest |
| dec_done | input | 1 | Decryption engine finished |
| dec_pass | input | 1 | Decryption tag verdict, valid with dec_done |
| clr_done | input | 1 | Configuration clear finished |
| buffer_cmd | output | 1 | Buffer the image |
| decrypt_cmd | output | 1 | Decrypt the image |
| clear_cmd | output | 1 | Clear configuration state |
| fallback_cmd | output | 1 | Load the fallback image |
| startup_cmd | output | 1 | Release the device |
| if_locked | output | 1 | Configuration interface locked |
| auth_error | output | 1 | Sticky authentication error |
| state_oh | output | 8 | One-hot state |

## Verification
Every command output is decoded directly from the registered state. A wrong transition therefore appears on the ports one clock after the triggering input.

Three kinds of fault each show up at specific points:
- A premature compare, or a missed done flag, shows as `state_oh` leaving or staying in buffering one cycle off.
- A missed bit in the digest comparison shows as `startup_cmd` rising for a corrupted image.
- A lost fallback marker shows as a second `clear_cmd` instead of `if_locked`.

The program-request filter is judged by when idle returns, which is four clocks after the request is first sampled.

// File: rtl/cfg_auth_pkg.sv
package cfg_auth_pkg;
  typedef enum logic [7:0] {
    ST_IDLE   = 8'b0000_0001,
    ST_BUFFER = 8'b0000_0010,
    ST_SIGCMP = 8'b0000_0100,
    ST_DECRYPT= 8'b0000_1000,
    ST_CLEAR  = 8'b0001_0000,
    ST_FBLOAD = 8'b0010_0000,
    ST_START  = 8'b0100_0000,
    ST_LOCKED = 8'b1000_0000
  } auth_state_e;

  // Route on a good verdict: encrypted images go to decryption, others start.
  function automatic auth_state_e pass_route(input logic enc);
    return enc ? ST_DECRYPT : ST_START;
  endfunction

  // Route on an error: one fallback attempt at most.
  function automatic auth_state_e fail_route(input logic fb_en, input logic fb_used);
    return (fb_en && !fb_used) ? ST_CLEAR : ST_LOCKED;
  endfunction
endpackage

// File: rtl/cfg_prog_filter.sv
module cfg_prog_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic prog_req,
  output logic prog_valid
);
  localparam int CHAIN = SYNC_STAGES + 1;
  logic [CHAIN-1:0] sh;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sh <= '0;
    else        sh <= {sh[CHAIN-2:0], prog_req};
  end

  // Valid only when the synchronised level is high on two successive samples.
  assign prog_valid = sh[CHAIN-1] & sh[CHAIN-2];
endmodule

// File: rtl/cfg_digest_cmp.sv
module cfg_digest_cmp #(
  parameter int DW   = 256,
  parameter int LANE = 32
) (
  input  logic [DW-1:0] exp_d,
  input  logic [DW-1:0] act_d,
  output logic          match
);
  localparam int NL = (DW + LANE - 1) / LANE;
  localparam int PW = NL * LANE;
  logic [PW-1:0] ep, ap;
  logic [NL-1:0] lane_eq;

  assign ep = PW'(exp_d);
  assign ap = PW'(act_d);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lane_eq[g] = (ep[g*LANE +: LANE] == ap[g*LANE +: LANE]);
  end

  assign match = &lane_eq;
endmodule

// File: rtl/cfg_auth_fsm.sv
module cfg_auth_fsm
  import cfg_auth_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic        prog_valid,
  input  logic        start,
  input  logic        encrypted,
  input  logic        sig_en,
  input  logic        fallback_en,
  input  logic        buf_done,
  input  logic        hash_done,
  input  logic        digest_match,
  input  logic        dec_done,
  input  logic        dec_pass,
  input  logic        clr_done,
  output auth_state_e state,
  output logic        auth_error,
  output logic        fb_used,
  output logic        fail_evt,
  output logic        both_ready
);
  auth_state_e nxt;
  logic enc_q, buf_seen, hash_seen;
  logic accept;

  assign accept     = (state == ST_IDLE || state == ST_FBLOAD) && start;
  assign both_ready = (buf_seen | buf_done) & (hash_seen | hash_done);

  always_comb begin
    nxt      = state;
    fail_evt = 1'b0;
    case (state)
      ST_IDLE, ST_FBLOAD:
        if (start) nxt = sig_en ? ST_BUFFER : pass_route(encrypted);
      ST_BUFFER:
        if (both_ready) nxt = ST_SIGCMP;
      ST_SIGCMP:
        if (digest_match) nxt = pass_route(enc_q);
        else              fail_evt = 1'b1;
      ST_DECRYPT:
        if (dec_done) begin
          if (dec_pass) nxt = ST_START;
          else          fail_evt = 1'b1;
        end
      ST_CLEAR:
        if (clr_done) nxt = ST_FBLOAD;
      default: nxt = state;
    endcase
    if (fail_evt) nxt = fail_route(fallback_en, fb_used);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state      <= ST_IDLE;
      enc_q      <= 1'b0;
      buf_seen   <= 1'b0;
      hash_seen  <= 1'b0;
      auth_error <= 1'b0;
      fb_used    <= 1'b0;
    end else if (prog_valid) begin
      state      <= ST_IDLE;
      enc_q      <= 1'b0;
      buf_seen   <= 1'b0;
      hash_seen  <= 1'b0;
      auth_error <= 1'b0;
      fb_used    <= 1'b0;
    end else begin
      state      <= nxt;
      if (accept) enc_q <= encrypted;
      buf_seen   <= (state == ST_BUFFER) && (buf_seen | buf_done);
      hash_seen  <= (state == ST_BUFFER) && (hash_seen | hash_done);
      auth_error <= auth_error | fail_evt;
      fb_used    <= fb_used | (nxt == ST_FBLOAD);
    end
  end
endmodule

// File: rtl/cfg_auth_ctrl.sv
module cfg_auth_ctrl
  import cfg_auth_pkg::*;
#(
  parameter int DW   = 256,
  parameter int LANE = 32
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          prog_req,
  input  logic          start,
  input  logic          encrypted,
  input  logic          sig_en,
  input  logic          fallback_en,
  input  logic          buf_done,
  input  logic          hash_done,
  input  logic [DW-1:0] exp_digest,
  input  logic [DW-1:0] act_digest,
  input  logic          dec_done,
  input  logic          dec_pass,
  input  logic          clr_done,
  output logic          buffer_cmd,
  output logic          decrypt_cmd,
  output logic          clear_cmd,
  output logic          fallback_cmd,
  output logic          startup_cmd,
  output logic          if_locked,
  output logic          auth_error,
  output logic [7:0]    state_oh
);
  logic        prog_valid, digest_match, fb_used, fail_evt, both_ready;
  auth_state_e state;

  cfg_prog_filter #(.SYNC_STAGES(2)) u_prog (
    .clk(clk), .por_n(por_n), .prog_req(prog_req), .prog_valid(prog_valid)
  );

  cfg_digest_cmp #(.DW(DW), .LANE(LANE)) u_cmp (
    .exp_d(exp_digest), .act_d(act_digest), .match(digest_match)
  );

  cfg_auth_fsm u_fsm (
    .clk(clk), .por_n(por_n), .prog_valid(prog_valid), .start(start),
    .encrypted(encrypted), .sig_en(sig_en), .fallback_en(fallback_en),
    .buf_done(buf_done), .hash_done(hash_done), .digest_match(digest_match),
    .dec_done(dec_done), .dec_pass(dec_pass), .clr_done(clr_done),
    .state(state), .auth_error(auth_error), .fb_used(fb_used),
    .fail_evt(fail_evt), .both_ready(both_ready)
  );

  assign state_oh     = state;
  assign buffer_cmd   = state[1];
  assign decrypt_cmd  = state[3];
  assign clear_cmd    = state[4];
  assign fallback_cmd = state[5];
  assign startup_cmd  = state[6];
  assign if_locked    = state[7];
endmodule

// File: rtl/cfg_auth_chk.sv
module cfg_auth_chk (
  input logic       clk,
  input logic       por_n,
  input logic       prog_valid,
  input logic       digest_match,
  input logic       fail_evt,
  input logic       fb_used,
  input logic [7:0] state_oh,
  input logic       decrypt_cmd,
  input logic       startup_cmd,
  input logic       clear_cmd,
  input logic       fallback_cmd,
  input logic       if_locked,
  input logic       auth_error
);
  assert_onehot_R1: assert property (@(posedge clk) disable iff (!por_n)
    $countones(state_oh) == 1);

  assert_cmp_after_buffer_R2: assert property (@(posedge clk) disable iff (!por_n)
    (state_oh[2] && !$past(prog_valid)) |-> $past(state_oh[1]));

  assert_no_decrypt_early_R4: assert property (@(posedge clk) disable iff (!por_n)
    (state_oh[1] || state_oh[2]) |-> !decrypt_cmd);

  assert_mismatch_no_start_R5: assert property (@(posedge clk) disable iff (!por_n)
    (state_oh[2] && !digest_match) |=> !startup_cmd);

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
    (auth_error && !prog_valid) |=> auth_error);

  assert_clear_before_fb_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(fallback_cmd) |-> $past(clear_cmd));

  assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!por_n)
    (if_locked && !prog_valid) |=> if_locked);

  assert_single_fallback_R9: assert property (@(posedge clk) disable iff (!por_n)
    (fail_evt && fb_used && !prog_valid) |=> if_locked);
endmodule

bind cfg_auth_ctrl cfg_auth_chk u_chk (
  .clk(clk), .por_n(por_n), .prog_valid(prog_valid), .digest_match(digest_match),
  .fail_evt(fail_evt), .fb_used(fb_used), .state_oh(state_oh),
  .decrypt_cmd(decrypt_cmd), .startup_cmd(startup_cmd), .clear_cmd(clear_cmd),
  .fallback_cmd(fallback_cmd), .if_locked(if_locked), .auth_error(auth_error)
);

// File: tb/sim_cfg_auth_ctrl.sv
module sim_cfg_auth_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] S_IDLE = 8'h01, S_BUF = 8'h02, S_CMP = 8'h04,
    S_DEC = 8'h08, S_CLR = 8'h10, S_FB = 8'h20, S_START = 8'h40, S_LOCK = 8'h80;

  logic clk = 1'b0, por_n = 1'b0, prog_req = 1'b0, start = 1'b0, encrypted = 1'b0;
  logic sig_en = 1'b0, fallback_en = 1'b0, buf_done = 1'b0, hash_done = 1'b0;
  logic dec_done = 1'b0, dec_pass = 1'b0, clr_done = 1'b0;
  logic [255:0] exp_digest = '0, act_digest = '0;
  logic buffer_cmd, decrypt_cmd, clear_cmd, fallback_cmd, startup_cmd, if_locked, auth_error;
  logic [7:0] state_oh;
  int n_chk = 0, n_bad = 0;
  logic [255:0] golden;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_auth_ctrl u0 (.*);

  initial begin
    #(CLK_PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance one clock, sample 1 time unit after the edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    por_n = 1'b0; start = 0; buf_done = 0; hash_done = 0; dec_done = 0;
    dec_pass = 0; clr_done = 0; prog_req = 0;
    #1;
    chk("R1 reset state", {24'd0, state_oh}, {24'd0, S_IDLE});
    chk("R1 reset cmds", {25'd0, buffer_cmd, decrypt_cmd, clear_cmd, fallback_cmd,
        startup_cmd, if_locked, auth_error}, 32'd0);
    @(negedge clk);
    por_n = 1'b1;
  endtask

  // pulse one input for a single cycle starting at a falling edge
  task automatic go_start(input logic enc, input logic sig);
    @(negedge clk);
    encrypted = enc; sig_en = sig; start = 1;
    step();
    @(negedge clk);
    start = 0;
  endtask

  task automatic buffer_phase(input logic [255:0] act);
    act_digest = act;
    buf_done = 1; step(); @(negedge clk); buf_done = 0;
    chk("R2 waits for digest", {24'd0, state_oh}, {24'd0, S_BUF});
    hash_done = 1; step(); @(negedge clk); hash_done = 0;
    chk("R2 compare state", {24'd0, state_oh}, {24'd0, S_CMP});
    step();
  endtask

  task automatic t_plain_pass();
    do_reset(); fallback_en = 0;
    go_start(1'b0, 1'b1);
    chk("R2 buffering", {31'd0, buffer_cmd}, 32'd1);
    buffer_phase(golden);
    chk("R3 startup", {24'd0, state_oh}, {24'd0, S_START});
    step(3);
    chk("R3 startup holds", {31'd0, startup_cmd}, 32'd1);
  endtask

  task automatic t_enc_pass();
    do_reset();
    go_start(1'b1, 1'b1);
    // both done flags in the same cycle
    act_digest = golden;
    @(negedge clk); buf_done = 1; hash_done = 1; step();
    @(negedge clk); buf_done = 0; hash_done = 0;
    chk("R2 same-cycle done", {24'd0, state_oh}, {24'd0, S_CMP});
    chk("R4 no decrypt in compare", {31'd0, decrypt_cmd}, 32'd0);
    step();
    chk("R4 decrypt after match", {24'd0, state_oh}, {24'd0, S_DEC});
    @(negedge clk); dec_done = 1; dec_pass = 1; step();
    @(negedge clk); dec_done = 0; dec_pass = 0;
    chk("R4 startup after tag pass", {24'd0, state_oh}, {24'd0, S_START});
  endtask

  task automatic t_bitflip_lock(input int bitpos);
    do_reset(); fallback_en = 0;
    go_start(1'b0, 1'b1);
    buffer_phase(golden ^ (256'd1 << bitpos));
    chk($sformatf("R5 flip bit %0d no startup", bitpos), {31'd0, startup_cmd}, 32'd0);
    chk("R7 locked", {24'd0, state_oh}, {24'd0, S_LOCK});
    chk("R6 error flag", {31'd0, auth_error}, 32'd1);
    @(negedge clk); start = 1; sig_en = 0; dec_done = 1; dec_pass = 1; clr_done = 1;
    step(3);
    @(negedge clk); start = 0; dec_done = 0; dec_pass = 0; clr_done = 0;
    chk("R7 traffic ignored", {24'd0, state_oh}, {24'd0, S_LOCK});
  endtask

  task automatic t_prog();
    // LOCKED from the previous scenario
    @(negedge clk); prog_req = 1; step(); @(negedge clk); prog_req = 0;
    step(6);
    chk("R8 short pulse ignored", {24'd0, state_oh}, {24'd0, S_LOCK});
    @(negedge clk); prog_req = 1; step(4); @(negedge clk); prog_req = 0;
    step(3);
    chk("R8 program releases", {24'd0, state_oh}, {24'd0, S_IDLE});
    chk("R8 error cleared", {31'd0, auth_error}, 32'd0);
  endtask

  task automatic t_fallback();
    do_reset(); fallback_en = 1;
    go_start(1'b1, 1'b0);
    chk("R10 direct decrypt", {24'd0, state_oh}, {24'd0, S_DEC});
    @(negedge clk); dec_done = 1; dec_pass = 0; step();
    @(negedge clk); dec_done = 0;
    chk("R5 tag failure to clear", {24'd0, state_oh}, {24'd0, S_CLR});
    step(3);
    chk("R6 clear held", {31'd0, clear_cmd}, 32'd1);
    @(negedge clk); clr_done = 1; step(); @(negedge clk); clr_done = 0;
    chk("R6 fallback load", {24'd0, state_oh}, {24'd0, S_FB});
    chk("R6 error sticky", {31'd0, auth_error}, 32'd1);
    go_start(1'b0, 1'b1);
    buffer_phase(golden ^ (256'd1 << 200));
    chk("R9 second failure locks", {24'd0, state_oh}, {24'd0, S_LOCK});
  endtask

  task automatic t_fallback_pass();
    do_reset(); fallback_en = 1;
    go_start(1'b0, 1'b1);
    buffer_phase(golden ^ (256'd1 << 37));
    chk("R6 sig failure to clear", {24'd0, state_oh}, {24'd0, S_CLR});
    @(negedge clk); clr_done = 1; step(); @(negedge clk); clr_done = 0;
    go_start(1'b0, 1'b0);
    chk("R10 direct startup", {24'd0, state_oh}, {24'd0, S_START});
  endtask

  initial begin
    golden = {8{32'hC0DE_5EED}} ^ {64'h1234_5678_9ABC_DEF0, 192'd0};
    exp_digest = golden;
    t_plain_pass();
    t_enc_pass();
    t_bitflip_lock(0);
    t_bitflip_lock(131);
    t_bitflip_lock(255);
    t_prog();
    t_fallback();
    t_fallback_pass();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule